// File: doc/BRIEF.md
# Flash Command and Status Sequencer

This block runs the command protocol of a 32-bit NOR flash bank made of two 16-bit devices side by side. A host hands it one operation at a time: an identifier probe, a block erase or a single-word program. The block then issues the bus writes and reads the devices expect. It polls their status until both halves report ready and puts the bank back into read-array mode. Finally it reports the outcome with a one-cycle done pulse, a pass flag and a timeout flag.

Every command is sent as one 8-bit code placed in both 16-bit halves of the word, so both devices act together. The bus side is a simple request/acknowledge port. The sequencer holds a request steady until it is acknowledged, and each cycle in which request and acknowledge are both high completes exactly one transfer. A poll limit set by a parameter ends an operation that never becomes ready, so a dead device cannot hang the host.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, and while no operation has been accepted, `busy`, `done`, `pass`, `timeout` and `bus_req` are all 0.
- R2: An operation is accepted only on a cycle with `op_valid` high and `busy` low, and `op_valid` while busy has no effect. A pending bus request keeps `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` unchanged until `bus_ack`. Each cycle with `bus_req` and `bus_ack` both high completes one transfer.
- R3: Every command word is `{8'h00, code, 8'h00, code}`, with these codes: read-array FF, read-ID 90, erase setup 20, erase confirm D0, program setup 40, status read 70.
- R4: Erase (`op_code` 1) writes erase setup, then erase confirm, to `op_addr`, then polls.
- R5: Program (`op_code` 2) writes program setup, then `op_wdata`, to `op_addr`, then polls. After read-array it does one read of `op_addr`.
- R6: Each poll writes status read to `op_addr` and then reads `op_addr`. Polling stops only when the status has both bits 0x00800080 set, so one ready half keeps it polling.
- R7: When polling ends, read-array is written to `op_addr` before `done` rises.
- R8: Erase fails when any bit of 0x00200020 is set in the last status; program fails when any bit of 0x00100010 is set; the other operation's error bits are ignored.
- R9: Program fails when the read after read-array differs from `op_wdata`.
- R10: Probe (`op_code` 0) writes read-ID to address 0, reads address 0 (manufacturer) and address 1 (device), then writes read-array to address 0. It passes only for manufacturer 0x00890089 and device 0x88F388F3 or 0x88F488F4.
- R11: After POLL_LIMIT status reads without ready, read-array is written and the operation ends with `pass`=0 and `timeout`=1. A timed-out program skips its verify read.
- R12: `done` is a one-cycle pulse; `pass` and `timeout` are 0 except in the `done` cycle. `op_code` 3 is reserved: it makes no bus transfer and ends with `done`, `pass`=0, `timeout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 2 | 0 probe, 1 erase, 2 program, 3 reserved |
| op_addr | input | AW (22) | Word address of the operation |
| op_wdata | input | 32 | Word to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation succeeded (with done) |
| timeout | output | 1 | Poll limit reached (with done) |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | AW (22) | Bus word address |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | Transfer acknowledge |
| bus_rdata | input | 32 | Read data, valid with bus_ack on a read |

## Verification
The assertions assume that the bus side acknowledges only a transfer that is being requested, and returns read data in the acknowledge cycle. They also assume that the host keeps `op_code` legal while `op_valid` is high. The bench's device model raises `bus_ack` only while `bus_req` is high, after zero or one wait cycle, and drives `bus_rdata` in that same cycle. Host stimulus changes only on falling edges and comes with the operation codes the requirements define.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam int HALF_W = 16;
  localparam int DW     = 2 * HALF_W;

  typedef enum logic [1:0] {
    OP_PROBE   = 2'd0,
    OP_ERASE   = 2'd1,
    OP_PROGRAM = 2'd2,
    OP_RSVD    = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SETUP,
    S_SECOND,
    S_PCMD,
    S_PRD,
    S_IDM,
    S_IDD,
    S_RST,
    S_VRD,
    S_DONE
  } st_e;

  // same half-word on both devices
  function automatic logic [DW-1:0] both_halves(input logic [HALF_W-1:0] h);
    return {h, h};
  endfunction

  // 8-bit command code widened and sent to both devices
  function automatic logic [DW-1:0] cmd_word(input logic [7:0] c);
    return both_halves({{(HALF_W-8){1'b0}}, c});
  endfunction

  localparam logic [7:0] CODE_ARRAY  = 8'hFF;
  localparam logic [7:0] CODE_IDENT  = 8'h90;
  localparam logic [7:0] CODE_ESETUP = 8'h20;
  localparam logic [7:0] CODE_ECONF  = 8'hD0;
  localparam logic [7:0] CODE_PSETUP = 8'h40;
  localparam logic [7:0] CODE_STAT   = 8'h70;

  localparam logic [DW-1:0] MASK_READY = both_halves(16'h0080);
  localparam logic [DW-1:0] MASK_EERR  = both_halves(16'h0020);
  localparam logic [DW-1:0] MASK_PERR  = both_halves(16'h0010);
  localparam logic [DW-1:0] ID_MAKER   = both_halves(16'h0089);
  localparam logic [DW-1:0] ID_PART_T  = both_halves(16'h88F3);
  localparam logic [DW-1:0] ID_PART_B  = both_halves(16'h88F4);

endpackage

// File: rtl/fseq_rst_sync.sv
module fseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/fseq_poll_timer.sv
module fseq_poll_timer #(
  parameter int POLL_LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic expired
);

  localparam int CW = $clog2(POLL_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(POLL_LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = (cnt_q == LAST);

  always_comb begin
    cnt_en = clr | (step & ~expired);
    cnt_d  = clr ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_poll_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  assert_poll_count_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !expired) |=> (cnt_q == $past(cnt_q) + CW'(1)));

endmodule

// File: rtl/fseq_judge.sv
module fseq_judge
  import flash_seq_pkg::*;
(
  input  op_e           op,
  input  logic          timed_out,
  input  logic [DW-1:0] status,
  input  logic [DW-1:0] maker,
  input  logic [DW-1:0] part,
  input  logic [DW-1:0] readback,
  input  logic [DW-1:0] written,
  output logic          ok
);

  always_comb begin
    unique case (op)
      OP_PROBE:   ok = (maker == ID_MAKER) && ((part == ID_PART_T) || (part == ID_PART_B));
      OP_ERASE:   ok = !timed_out && ((status & MASK_EERR) == '0);
      OP_PROGRAM: ok = !timed_out && ((status & MASK_PERR) == '0) && (readback == written);
      default:    ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/fseq_fsm.sv
module fseq_fsm
  import flash_seq_pkg::*;
#(
  parameter int AW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_code,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  input  logic          poll_expired,
  input  logic          judge_ok,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          timeout,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          poll_clr,
  output logic          poll_step,
  output op_e           op_q,
  output logic          to_q,
  output logic [DW-1:0] stat_q,
  output logic [DW-1:0] maker_q,
  output logic [DW-1:0] part_q,
  output logic [DW-1:0] vrd_q,
  output logic [DW-1:0] data_q
);

  st_e           st_q, st_d;
  logic [AW-1:0] addr_q;
  logic          accept, ready, to_set;

  assign accept    = (st_q == S_IDLE) && op_valid;
  assign ready     = (bus_rdata & MASK_READY) == MASK_READY;
  assign poll_clr  = accept;
  assign poll_step = (st_q == S_PRD) && bus_ack && !ready;

  // next state
  always_comb begin
    st_d   = st_q;
    to_set = 1'b0;
    unique case (st_q)
      S_IDLE:   if (op_valid) st_d = (op_e'(op_code) == OP_RSVD) ? S_DONE : S_SETUP;
      S_SETUP:  if (bus_ack) st_d = (op_q == OP_PROBE) ? S_IDM : S_SECOND;
      S_SECOND: if (bus_ack) st_d = S_PCMD;
      S_PCMD:   if (bus_ack) st_d = S_PRD;
      S_PRD: begin
        if (bus_ack) begin
          if (ready) begin
            st_d = S_RST;
          end else if (poll_expired) begin
            st_d   = S_RST;
            to_set = 1'b1;
          end else begin
            st_d = S_PCMD;
          end
        end
      end
      S_IDM:    if (bus_ack) st_d = S_IDD;
      S_IDD:    if (bus_ack) st_d = S_RST;
      S_RST:    if (bus_ack) st_d = (op_q == OP_PROGRAM && !to_q) ? S_VRD : S_DONE;
      S_VRD:    if (bus_ack) st_d = S_DONE;
      S_DONE:   st_d = S_IDLE;
      default:  st_d = S_IDLE;
    endcase
  end

  // bus drive
  always_comb begin
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = addr_q;
    bus_wdata = '0;
    unique case (st_q)
      S_SETUP: begin
        bus_req = 1'b1;
        bus_we  = 1'b1;
        if (op_q == OP_PROBE) begin
          bus_addr  = '0;
          bus_wdata = cmd_word(CODE_IDENT);
        end else if (op_q == OP_ERASE) begin
          bus_wdata = cmd_word(CODE_ESETUP);
        end else begin
          bus_wdata = cmd_word(CODE_PSETUP);
        end
      end
      S_SECOND: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_wdata = (op_q == OP_ERASE) ? cmd_word(CODE_ECONF) : data_q;
      end
      S_PCMD: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_wdata = cmd_word(CODE_STAT);
      end
      S_PRD, S_VRD: bus_req = 1'b1;
      S_IDM: begin
        bus_req  = 1'b1;
        bus_addr = '0;
      end
      S_IDD: begin
        bus_req  = 1'b1;
        bus_addr = AW'(1);
      end
      S_RST: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = (op_q == OP_PROBE) ? '0 : addr_q;
        bus_wdata = cmd_word(CODE_ARRAY);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_PROBE;
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      op_q   <= op_e'(op_code);
      addr_q <= op_addr;
      data_q <= op_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           to_q <= 1'b0;
    else if (accept)      to_q <= 1'b0;
    else if (to_set)      to_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          stat_q <= '0;
    else if (st_q == S_PRD && bus_ack)   stat_q <= bus_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          maker_q <= '0;
    else if (st_q == S_IDM && bus_ack)   maker_q <= bus_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          part_q <= '0;
    else if (st_q == S_IDD && bus_ack)   part_q <= bus_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          vrd_q <= '0;
    else if (st_q == S_VRD && bus_ack)   vrd_q <= bus_rdata;
  end

  assign busy    = (st_q != S_IDLE);
  assign done    = (st_q == S_DONE);
  assign pass    = done && judge_ok;
  assign timeout = done && to_q;

  assert_bus_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

  assert_cmd_halves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && !(st_q == S_SECOND && op_q == OP_PROGRAM))
      |-> (bus_wdata[DW-1:HALF_W] == bus_wdata[HALF_W-1:0]));

  assert_poll_read_after_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == S_PRD) |-> ($past(st_q) == S_PCMD));

  assert_done_after_readarray_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(st_q) == S_RST || $past(st_q) == S_VRD || $past(st_q) == S_IDLE));

  assert_timeout_fails_R11: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> !pass);

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_flags_with_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pass || timeout) |-> done);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int AW         = 22,
  parameter int POLL_LIMIT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_code,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_wdata,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          timeout,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata
);

  logic          rst_sync_n;
  logic          poll_clr, poll_step, poll_expired, judge_ok, to_q;
  op_e           op_q;
  logic [DW-1:0] stat_q, maker_q, part_q, vrd_q, data_q;

  fseq_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fseq_poll_timer #(.POLL_LIMIT(POLL_LIMIT)) i_poll_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (poll_clr),
    .step    (poll_step),
    .expired (poll_expired)
  );

  fseq_judge i_judge (
    .op        (op_q),
    .timed_out (to_q),
    .status    (stat_q),
    .maker     (maker_q),
    .part      (part_q),
    .readback  (vrd_q),
    .written   (data_q),
    .ok        (judge_ok)
  );

  fseq_fsm #(.AW(AW)) i_fsm (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .op_valid     (op_valid),
    .op_code      (op_code),
    .op_addr      (op_addr),
    .op_wdata     (op_wdata),
    .bus_ack      (bus_ack),
    .bus_rdata    (bus_rdata),
    .poll_expired (poll_expired),
    .judge_ok     (judge_ok),
    .busy         (busy),
    .done         (done),
    .pass         (pass),
    .timeout      (timeout),
    .bus_req      (bus_req),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .poll_clr     (poll_clr),
    .poll_step    (poll_step),
    .op_q         (op_q),
    .to_q         (to_q),
    .stat_q       (stat_q),
    .maker_q      (maker_q),
    .part_q       (part_q),
    .vrd_q        (vrd_q),
    .data_q       (data_q)
  );

endmodule

// File: tb/test_flash_cmd_seq.sv
`timescale 1ns/1ps
module test_flash_cmd_seq;

  localparam int AW    = 22;
  localparam int LIMIT = 16;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] addr;
    logic [31:0] data;
    logic [7:0]  nbusy;
    logic [31:0] bword;
    logic [31:0] err;
    logic [31:0] corrupt;
    logic [1:0]  wait_n;
    logic        exp_pass;
    logic        exp_to;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 32'h0001000, 32'h0,        8'd3,   32'h0,        32'h0,        32'h0,        2'd0, 1'b1, 1'b0},
    '{2'd1, 32'h0002345, 32'h0,        8'd0,   32'h0,        32'h00000020, 32'h0,        2'd0, 1'b0, 1'b0},
    '{2'd1, 32'h03F0000, 32'h0,        8'd2,   32'h0,        32'h00200000, 32'h0,        2'd1, 1'b0, 1'b0},
    '{2'd1, 32'h0000040, 32'h0,        8'd1,   32'h0,        32'h00100010, 32'h0,        2'd1, 1'b1, 1'b0},
    '{2'd2, 32'h0000ABC, 32'hDEADBEEF, 8'd2,   32'h0,        32'h0,        32'h0,        2'd1, 1'b1, 1'b0},
    '{2'd2, 32'h0001234, 32'h12345678, 8'd0,   32'h0,        32'h00100000, 32'h0,        2'd0, 1'b0, 1'b0},
    '{2'd2, 32'h0005555, 32'hCAFEF00D, 8'd1,   32'h0,        32'h0,        32'h00000100, 2'd0, 1'b0, 1'b0},
    '{2'd2, 32'h0000777, 32'h0F0F0F0F, 8'd0,   32'h0,        32'h00200020, 32'h0,        2'd1, 1'b1, 1'b0},
    '{2'd1, 32'h0020000, 32'h0,        8'd5,   32'h00000080, 32'h0,        32'h0,        2'd0, 1'b1, 1'b0},
    '{2'd2, 32'h0030001, 32'hA5A55A5A, 8'd5,   32'h00800000, 32'h0,        32'h0,        2'd1, 1'b1, 1'b0},
    '{2'd1, 32'h0011111, 32'h0,        8'd200, 32'h0,        32'h0,        32'h0,        2'd0, 1'b0, 1'b1},
    '{2'd2, 32'h0022222, 32'h11223344, 8'd200, 32'h0,        32'h0,        32'h0,        2'd1, 1'b0, 1'b1}
  };

  logic          clk, rst_n;
  logic          op_valid;
  logic [1:0]    op_code;
  logic [AW-1:0] op_addr;
  logic [31:0]   op_wdata;
  logic          busy, done, pass, timeout;
  logic          bus_req, bus_we, bus_ack;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;

  flash_cmd_seq #(.AW(AW), .POLL_LIMIT(LIMIT)) i_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_addr(op_addr), .op_wdata(op_wdata), .busy(busy), .done(done),
    .pass(pass), .timeout(timeout), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // device model state
  int          m_mode;
  logic        m_expect_data;
  logic [31:0] m_mem, m_bword, m_err, m_corrupt, m_maker, m_part;
  int          m_nbusy, m_sreads, m_wait, wait_cnt;
  logic        pending;
  logic [AW-1:0] h_addr;
  logic        h_we;
  logic [31:0] h_wdata;
  int          stab_err;

  // transfer log
  logic          log_we   [64];
  logic [AW-1:0] log_addr [64];
  logic [31:0]   log_d    [64];
  int            log_n;

  logic          exp_we   [64];
  logic [AW-1:0] exp_addr [64];
  logic [31:0]   exp_d    [64];
  int            exp_n;

  function automatic logic [31:0] cw(input logic [7:0] c);
    return {8'h00, c, 8'h00, c};
  endfunction

  always @(negedge clk) begin
    bus_ack = 1'b0;
    if (bus_req) begin
      if (pending && (bus_addr != h_addr || bus_we != h_we || bus_wdata != h_wdata))
        stab_err++;
      pending = 1'b1;
      h_addr  = bus_addr;
      h_we    = bus_we;
      h_wdata = bus_wdata;
      if (wait_cnt < m_wait) begin
        wait_cnt++;
      end else begin
        bus_ack  = 1'b1;
        wait_cnt = 0;
        pending  = 1'b0;
        if (bus_we) begin
          if (m_expect_data) begin
            m_mem = bus_wdata;
            m_expect_data = 1'b0;
          end else begin
            case (bus_wdata[7:0])
              8'hFF: m_mode = 0;
              8'h90: m_mode = 1;
              8'h70: m_mode = 2;
              8'h40: m_expect_data = 1'b1;
              default: ;
            endcase
          end
        end else begin
          if (m_mode == 2) begin
            bus_rdata = (m_sreads < m_nbusy) ? m_bword : (32'h00800080 | m_err);
            m_sreads++;
          end else if (m_mode == 1) begin
            bus_rdata = (bus_addr == '0) ? m_maker : (bus_addr == AW'(1)) ? m_part : 32'h0;
          end else begin
            bus_rdata = m_mem ^ m_corrupt;
          end
        end
        if (log_n < 64) begin
          log_we[log_n]   = bus_we;
          log_addr[log_n] = bus_addr;
          log_d[log_n]    = bus_we ? bus_wdata : bus_rdata;
          log_n++;
        end
      end
    end else begin
      pending = 1'b0;
    end
  end

  task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic exp_push(input logic we, input logic [AW-1:0] a, input logic [31:0] d);
    exp_we[exp_n]   = we;
    exp_addr[exp_n] = a;
    exp_d[exp_n]    = d;
    exp_n++;
  endtask

  task automatic cmp_seq(input string what);
    int bad = -1;
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      if (bad < 0 && (log_we[i] != exp_we[i] || log_addr[i] != exp_addr[i] ||
                      (exp_we[i] && log_d[i] != exp_d[i])))
        bad = i;
    end
    chk(log_n == exp_n, {what, " transfer count"}, 32'(log_n), 32'(exp_n));
    if (bad >= 0)
      chk(1'b0, {what, " transfer content"}, {log_d[bad][31:8], 7'(bad), log_we[bad]},
          {exp_d[bad][31:8], 7'(bad), exp_we[bad]});
    else
      chk(1'b1, what, 32'h0, 32'h0);
  endtask

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [31:0] d,
                        output logic got_pass, output logic got_to);
    log_n    = 0;
    m_sreads = 0;
    op_valid = 1'b1;
    op_code  = op;
    op_addr  = a;
    op_wdata = d;
    @(negedge clk);
    op_valid = 1'b0;
    while (!done) @(negedge clk);
    got_pass = pass;
    got_to   = timeout;
    @(negedge clk);
    chk(!done && !pass && !timeout, "R12 done one cycle", {29'h0, done, pass, timeout}, 32'h0);
  endtask

  logic gp, gt;

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; op_addr = '0; op_wdata = '0;
    bus_ack = 1'b0; bus_rdata = '0;
    m_mode = 0; m_expect_data = 1'b0; m_mem = '0; m_bword = '0; m_err = '0;
    m_corrupt = '0; m_maker = '0; m_part = '0; m_nbusy = 0; m_sreads = 0;
    m_wait = 0; wait_cnt = 0; pending = 1'b0; stab_err = 0; log_n = 0; exp_n = 0;
    h_addr = '0; h_we = 1'b0; h_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk({busy, done, pass, timeout, bus_req} == 5'b0, "R1 idle after reset",
        {27'h0, busy, done, pass, timeout, bus_req}, 32'h0);

    // table walk: erase and program (R4 R5 R6 R7 R8 R9 R11)
    for (int v = 0; v < NV; v++) begin
      int polls;
      m_nbusy   = int'(VECS[v].nbusy);
      m_bword   = VECS[v].bword;
      m_err     = VECS[v].err;
      m_corrupt = VECS[v].corrupt;
      m_wait    = int'(VECS[v].wait_n);
      run_op(VECS[v].op, AW'(VECS[v].addr), VECS[v].data, gp, gt);
      chk(gp == VECS[v].exp_pass, $sformatf("R8 R9 pass flag vec %0d", v), 32'(gp), 32'(VECS[v].exp_pass));
      chk(gt == VECS[v].exp_to, $sformatf("R11 timeout flag vec %0d", v), 32'(gt), 32'(VECS[v].exp_to));
      polls = VECS[v].exp_to ? LIMIT : m_nbusy + 1;
      exp_n = 0;
      if (VECS[v].op == 2'd1) begin
        exp_push(1'b1, AW'(VECS[v].addr), cw(8'h20));
        exp_push(1'b1, AW'(VECS[v].addr), cw(8'hD0));
      end else begin
        exp_push(1'b1, AW'(VECS[v].addr), cw(8'h40));
        exp_push(1'b1, AW'(VECS[v].addr), VECS[v].data);
      end
      for (int p = 0; p < polls; p++) begin
        exp_push(1'b1, AW'(VECS[v].addr), cw(8'h70));
        exp_push(1'b0, AW'(VECS[v].addr), 32'h0);
      end
      exp_push(1'b1, AW'(VECS[v].addr), cw(8'hFF));
      if (VECS[v].op == 2'd2 && !VECS[v].exp_to)
        exp_push(1'b0, AW'(VECS[v].addr), 32'h0);
      cmp_seq($sformatf("R3 R4 R5 R6 R7 sequence vec %0d", v));
    end
    m_corrupt = '0; m_err = '0; m_nbusy = 0;

    // R10 probe cases
    begin
      logic [31:0] mk [5] = '{32'h00890089, 32'h00890089, 32'h00890089, 32'h00890088, 32'h00890089};
      logic [31:0] pt [5] = '{32'h88F388F3, 32'h88F488F4, 32'h88F188F1, 32'h88F388F3, 32'h88F388F4};
      logic        ex [5] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
      for (int k = 0; k < 5; k++) begin
        m_maker = mk[k];
        m_part  = pt[k];
        m_wait  = k % 2;
        run_op(2'd0, AW'(22'h12345), 32'h0, gp, gt);
        chk(gp == ex[k] && !gt, $sformatf("R10 probe result %0d", k), {30'h0, gp, gt}, {30'h0, ex[k], 1'b0});
        exp_n = 0;
        exp_push(1'b1, '0, cw(8'h90));
        exp_push(1'b0, '0, 32'h0);
        exp_push(1'b0, AW'(1), 32'h0);
        exp_push(1'b1, '0, cw(8'hFF));
        cmp_seq($sformatf("R10 probe sequence %0d", k));
      end
    end

    // R12 reserved opcode: no transfers
    m_wait = 0;
    run_op(2'd3, AW'(22'h00100), 32'h0, gp, gt);
    chk(!gp && !gt, "R12 reserved opcode flags", {30'h0, gp, gt}, 32'h0);
    chk(log_n == 0, "R12 reserved opcode no transfers", 32'(log_n), 32'h0);

    // R2 op_valid while busy is ignored
    m_nbusy = 3; m_wait = 1; log_n = 0; m_sreads = 0;
    op_valid = 1'b1; op_code = 2'd1; op_addr = AW'(22'h00400); op_wdata = '0;
    @(negedge clk);
    op_valid = 1'b0;
    repeat (3) @(negedge clk);
    op_valid = 1'b1; op_code = 2'd2; op_addr = AW'(22'h00999); op_wdata = 32'h55555555;
    @(negedge clk);
    op_valid = 1'b0;
    while (!done) @(negedge clk);
    chk(pass, "R2 first op completes", 32'(pass), 32'h1);
    exp_n = 0;
    exp_push(1'b1, AW'(22'h00400), cw(8'h20));
    exp_push(1'b1, AW'(22'h00400), cw(8'hD0));
    for (int p = 0; p < 4; p++) begin
      exp_push(1'b1, AW'(22'h00400), cw(8'h70));
      exp_push(1'b0, AW'(22'h00400), 32'h0);
    end
    exp_push(1'b1, AW'(22'h00400), cw(8'hFF));
    cmp_seq("R2 busy request ignored");
    repeat (10) @(negedge clk);
    chk(!busy && !bus_req && !done, "R2 no queued op", {29'h0, busy, bus_req, done}, 32'h0);
    chk(log_n == exp_n, "R2 no extra transfers", 32'(log_n), 32'(exp_n));

    // R2 held bus outputs during wait cycles
    chk(stab_err == 0, "R2 request held until ack", 32'(stab_err), 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule